// File: doc/BRIEF.md
# Multi-mode timer/event counter

A 16-bit counting block made of two 8-bit halves, fed by a fixed 2-bit prescaler followed by an 8-bit programmable prescaler. Its base resolution is one instruction cycle: a cycle-rate enable input advances the prescaler chain and also samples the event input. A 2-bit mode register selects how the halves are grouped. They can be two prescaled timers, a prescaled low half with an event-counting high half, a cascaded 16-bit prescaled timer, or a cascaded 16-bit event counter.

Each half, or the cascaded pair, counts from zero up to its programmed match value. On the counting tick at which the match value is held, it returns to zero and raises a request flag. The low half and the high half have their own flags. The flags stay set until software clears them. Writing the mode register restarts both counters and the whole prescaler chain.

Top module: `tick_event_timer`

## Requirements
- R1: After reset both counts are zero, both flags are clear, the mode is 0, the prescaler reload is 0 and both match values are 8'hFF.
- R2: With reload value P, the prescaled tick occurs once every 4*(P+1) enabled cycles. The fixed stage counts enabled cycles modulo 4 and the programmable stage counts fixed-stage wraps from 0 to P.
- R3: Mode 0 (mode code 2'b00): each half is an independent timer stepped by the prescaled tick. On a tick it goes to zero and sets its own flag if it equals its match value, and increments otherwise.
- R4: Mode 1 (code 2'b01): the low half behaves as in mode 0 and the high half counts qualified events with the same match, wrap and flag rule.
- R5: Mode 2 (code 2'b10): the halves form one 16-bit value {high, low} stepped by the prescaled tick. It returns to zero and sets the high flag only when the whole value equals {high match, low match}, and it carries from low to high at 8'hFF.
- R6: Mode 3 (code 2'b11): the same 16-bit cascade as mode 2, stepped by qualified events.
- R7: The event input is sampled only in enabled cycles. An event counts when it is high in an enabled cycle and was low at the previous enabled sample. A pulse that covers no enabled cycle is not counted.
- R8: A flag stays set until its clear strobe. If a set and a clear occur in the same cycle, the flag is set.
- R9: A mode write zeroes both counts and both prescaler stages in the next cycle, suppresses counting in that cycle, and leaves the flags unchanged.
- R10: In the cascaded modes the low flag is never set.
- R11: While the cycle enable is low, neither the counts nor the prescaler advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | One-cycle pulse per instruction cycle |
| evt_in | input | 1 | Synchronised external event level |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | New mode code |
| pre_wr | input | 1 | Prescaler reload write strobe |
| pre_wdata | input | 8 | New prescaler reload value |
| lo_match_wr | input | 1 | Low match write strobe |
| lo_match_wdata | input | 8 | New low match value |
| hi_match_wr | input | 1 | High match write strobe |
| hi_match_wdata | input | 8 | New high match value |
| lo_flag_clr | input | 1 | Clear strobe for the low flag |
| hi_flag_clr | input | 1 | Clear strobe for the high flag |
| lo_flag | output | 1 | Low half match request flag |
| hi_flag | output | 1 | High half (or cascade) match request flag |
| lo_count | output | 8 | Low half count |
| hi_count | output | 8 | High half count |

## Verification
The hardest state to reach is the cascaded full match whose low match is 8'hFF. The value must carry through the low half several times before the high half reaches its match. The bench sets the reload to zero and the cycle enable to constant high, so a few thousand cycles bring it there. Event qualification is the other hard case. A pulse that falls wholly between enabled cycles must be dropped, so the bench places one-clock pulses inside gaps of the enable. A cycle-accurate reference model in the bench follows every mode, every write and every random clear, and the outputs are compared with it in every cycle.

// File: rtl/tev_pkg.sv
package tev_pkg;
   typedef enum logic [1:0] {
      TM_SPLIT_PP = 2'b00,
      TM_SPLIT_PE = 2'b01,
      TM_CASC_P   = 2'b10,
      TM_CASC_E   = 2'b11
   } tev_mode_e;
endpackage

// File: rtl/tev_prescaler.sv
module tev_prescaler #(
   parameter int FIX_W = 2,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_en,
   input  logic             restart,
   input  logic [PRE_W-1:0] reload,
   output logic             tick
);
   localparam logic [FIX_W-1:0] FIX_LAST = '1;

   logic [FIX_W-1:0] fix_q;
   logic [PRE_W-1:0] pcnt_q;
   logic             fix_tick;

   assign fix_tick = cyc_en & ~restart & (fix_q == FIX_LAST);
   assign tick     = fix_tick & (pcnt_q == reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fix_q <= '0;
      else if (restart)  fix_q <= '0;
      else if (cyc_en)   fix_q <= fix_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pcnt_q <= '0;
      else if (restart)   pcnt_q <= '0;
      else if (fix_tick)  pcnt_q <= (pcnt_q == reload) ? '0 : pcnt_q + 1'b1;
   end

   // R11: no enable, no advance
   p_fix_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_en && !restart) |=> $stable(fix_q));
   // R2: programmable stage restarts after its tick
   p_pre_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pcnt_q == '0));
endmodule

// File: rtl/tev_evt_qual.sv
module tev_evt_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_en,
   input  logic evt_lvl,
   output logic evt_tick
);
   logic samp_q;

   assign evt_tick = cyc_en & evt_lvl & ~samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      samp_q <= 1'b0;
      else if (cyc_en) samp_q <= evt_lvl;
   end

   // R7: a level must be seen low again before another event counts
   p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_tick |=> !evt_tick);
endmodule

// File: rtl/tev_half.sv
module tev_half #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         wrap,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (step)  cnt <= wrap ? '0 : cnt + 1'b1;
   end

   // R11: idle half keeps its value
   p_half_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(cnt));
   // R3: a step without wrap adds one
   p_half_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step && !wrap) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tick_event_timer.sv
module tick_event_timer #(
   parameter int HALF_W = 8,
   parameter int FIX_W  = 2,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              evt_in,
   input  logic              mode_wr,
   input  logic [1:0]        mode_wdata,
   input  logic              pre_wr,
   input  logic [PRE_W-1:0]  pre_wdata,
   input  logic              lo_match_wr,
   input  logic [HALF_W-1:0] lo_match_wdata,
   input  logic              hi_match_wr,
   input  logic [HALF_W-1:0] hi_match_wdata,
   input  logic              lo_flag_clr,
   input  logic              hi_flag_clr,
   output logic              lo_flag,
   output logic              hi_flag,
   output logic [HALF_W-1:0] lo_count,
   output logic [HALF_W-1:0] hi_count
);
   import tev_pkg::*;

   localparam int NHALF = 2;

   initial begin
      assert (HALF_W >= 2 && FIX_W >= 1 && PRE_W >= 1)
         else $error("tick_event_timer: width parameters out of range");
   end

   tev_mode_e         mode_q;
   logic [PRE_W-1:0]  pre_q;
   logic [HALF_W-1:0] match_q [NHALF];
   logic [HALF_W-1:0] cnt_v   [NHALF];
   logic              step_v  [NHALF];
   logic              wrap_v  [NHALF];

   logic p_tick, e_raw, e_tick, src_c, casc;
   logic lo_at, hi_at, full_at, lo_all1, lo_set, hi_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= TM_SPLIT_PP;
         pre_q      <= '0;
         match_q[0] <= '1;
         match_q[1] <= '1;
      end else begin
         if (mode_wr)     mode_q     <= tev_mode_e'(mode_wdata);
         if (pre_wr)      pre_q      <= pre_wdata;
         if (lo_match_wr) match_q[0] <= lo_match_wdata;
         if (hi_match_wr) match_q[1] <= hi_match_wdata;
      end
   end

   tev_prescaler #(.FIX_W(FIX_W), .PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .restart(mode_wr),
      .reload(pre_q), .tick(p_tick));

   tev_evt_qual u_evt (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .evt_lvl(evt_in),
      .evt_tick(e_raw));

   assign e_tick  = e_raw & ~mode_wr;
   assign casc    = mode_q[1];
   assign src_c   = (mode_q == TM_CASC_P) ? p_tick : e_tick;
   assign lo_at   = (cnt_v[0] == match_q[0]);
   assign hi_at   = (cnt_v[1] == match_q[1]);
   assign full_at = lo_at & hi_at;
   assign lo_all1 = &cnt_v[0];

   always_comb begin
      if (casc) begin
         step_v[0] = src_c;
         step_v[1] = src_c & (lo_all1 | full_at);
         wrap_v[0] = full_at;
         wrap_v[1] = full_at;
         lo_set    = 1'b0;
         hi_set    = src_c & full_at;
      end else begin
         step_v[0] = p_tick;
         step_v[1] = (mode_q == TM_SPLIT_PP) ? p_tick : e_tick;
         wrap_v[0] = lo_at;
         wrap_v[1] = hi_at;
         lo_set    = p_tick & lo_at;
         hi_set    = step_v[1] & hi_at;
      end
   end

   for (genvar gi = 0; gi < NHALF; gi++) begin : g_half
      tev_half #(.W(HALF_W)) u_half (
         .clk(clk), .rst_n(rst_n), .clr(mode_wr),
         .step(step_v[gi]), .wrap(wrap_v[gi]), .cnt(cnt_v[gi]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_flag <= 1'b0;
         hi_flag <= 1'b0;
      end else begin
         lo_flag <= lo_set | (lo_flag & ~lo_flag_clr);
         hi_flag <= hi_set | (hi_flag & ~hi_flag_clr);
      end
   end

   assign lo_count = cnt_v[0];
   assign hi_count = cnt_v[1];

   // R8: flags are sticky
   p_lo_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_flag && !lo_flag_clr) |=> lo_flag);
   p_hi_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_flag && !hi_flag_clr) |=> hi_flag);
   // R10: cascaded modes never raise the low flag
   p_casc_no_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (casc && !lo_flag && !mode_wr) |=> !lo_flag);
   // R9: mode write clears both halves
   p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (lo_count == '0 && hi_count == '0));
   // R3: split-mode low flag comes with a wrap to zero
   p_lo_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!casc && lo_set) |=> (lo_count == '0));
endmodule

// File: tb/tick_event_timer_bench.sv
module tick_event_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cyc_en = 0, evt_in = 0;
   logic mode_wr = 0, pre_wr = 0, lo_match_wr = 0, hi_match_wr = 0;
   logic [1:0] mode_wdata = 0;
   logic [7:0] pre_wdata = 0, lo_match_wdata = 0, hi_match_wdata = 0;
   logic lo_flag_clr = 0, hi_flag_clr = 0;
   logic lo_flag, hi_flag;
   logic [7:0] lo_count, hi_count;

   int total = 0, bad = 0, cycles = 0;
   bit done = 0, comparing = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   tick_event_timer u_tick_event_timer (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .evt_in(evt_in),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .pre_wr(pre_wr), .pre_wdata(pre_wdata),
      .lo_match_wr(lo_match_wr), .lo_match_wdata(lo_match_wdata),
      .hi_match_wr(hi_match_wr), .hi_match_wdata(hi_match_wdata),
      .lo_flag_clr(lo_flag_clr), .hi_flag_clr(hi_flag_clr),
      .lo_flag(lo_flag), .hi_flag(hi_flag),
      .lo_count(lo_count), .hi_count(hi_count));

   // reference model state
   logic [1:0] m_mode, m_fix;
   logic [7:0] m_pre, m_pcnt, m_lom, m_him, m_lo, m_hi;
   logic       m_lof, m_hif, m_samp;
   logic       ft, pt, et, tk, ls, hs;
   logic [15:0] v;

   function automatic logic [7:0] next_half(input logic [7:0] c, input logic [7:0] m);
      return (c == m) ? 8'h00 : c + 8'h01;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_fix = 0; m_pre = 0; m_pcnt = 0;
         m_lom = 8'hFF; m_him = 8'hFF; m_lo = 0; m_hi = 0;
         m_lof = 0; m_hif = 0; m_samp = 0;
      end else begin
         ft = cyc_en && (m_fix == 2'd3) && !mode_wr;
         pt = ft && (m_pcnt == m_pre);
         et = cyc_en && evt_in && !m_samp && !mode_wr;
         ls = 0; hs = 0;
         if (cyc_en) m_samp = evt_in;
         if (mode_wr) begin
            m_fix = 0; m_pcnt = 0; m_lo = 0; m_hi = 0;
         end else begin
            if (cyc_en) m_fix = m_fix + 2'd1;
            if (ft) m_pcnt = pt ? 8'd0 : m_pcnt + 8'd1;
            if (m_mode[1] == 1'b0) begin
               if (pt) begin ls = (m_lo == m_lom); m_lo = next_half(m_lo, m_lom); end
               tk = (m_mode == 2'd0) ? pt : et;
               if (tk) begin hs = (m_hi == m_him); m_hi = next_half(m_hi, m_him); end
            end else begin
               tk = (m_mode == 2'd2) ? pt : et;
               if (tk) begin
                  v = {m_hi, m_lo};
                  if (v == {m_him, m_lom}) begin v = 0; hs = 1; end
                  else v = v + 16'd1;
                  {m_hi, m_lo} = v;
               end
            end
         end
         m_lof = ls || (m_lof && !lo_flag_clr);
         m_hif = hs || (m_hif && !hi_flag_clr);
         if (mode_wr)     m_mode = mode_wdata;
         if (pre_wr)      m_pre  = pre_wdata;
         if (lo_match_wr) m_lom  = lo_match_wdata;
         if (hi_match_wr) m_him  = hi_match_wdata;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && comparing && !done) begin
         check(cur_req, "lo_count", {8'h0, lo_count}, {8'h0, m_lo});
         check(cur_req, "hi_count", {8'h0, hi_count}, {8'h0, m_hi});
         check(cur_req, "lo_flag", {15'h0, lo_flag}, {15'h0, m_lof});
         check(cur_req, "hi_flag", {15'h0, hi_flag}, {15'h0, m_hif});
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1; bad++; total++;
         $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic cfg(input logic [1:0] m, input logic [7:0] p,
                      input logic [7:0] lm, input logic [7:0] hm);
      @(negedge clk);
      mode_wr = 1; mode_wdata = m; pre_wr = 1; pre_wdata = p;
      lo_match_wr = 1; lo_match_wdata = lm; hi_match_wr = 1; hi_match_wdata = hm;
      @(negedge clk);
      mode_wr = 0; pre_wr = 0; lo_match_wr = 0; hi_match_wr = 0;
   endtask

   task automatic run(input int n, input int en_pct, input int evt_pct, input int clr_pct);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cyc_en = (($urandom % 100) < en_pct);
         if (($urandom % 100) < evt_pct) evt_in = ~evt_in;
         lo_flag_clr = (($urandom % 100) < clr_pct);
         hi_flag_clr = (($urandom % 100) < clr_pct);
      end
      @(negedge clk);
      lo_flag_clr = 0; hi_flag_clr = 0;
   endtask

   logic [7:0] snap_lo, snap_hi;
   int seed_init;

   initial begin
      seed_init = $urandom(32'h00C0FFEE);
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check("R1", "reset lo_count", {8'h0, lo_count}, 16'h0);
      check("R1", "reset hi_count", {8'h0, hi_count}, 16'h0);
      check("R1", "reset flags", {14'h0, lo_flag, hi_flag}, 16'h0);
      rst_n = 1;
      comparing = 1;

      // R1 defaults: mode 0, reload 0, match FF with steady enable
      run(300, 100, 0, 0);

      cur_req = "R3";
      cfg(2'd0, 8'd1, 8'd5, 8'd9);
      run(600, 80, 20, 3);

      cur_req = "R2";
      cfg(2'd0, 8'd0, 8'd0, 8'd0);
      run(200, 100, 0, 0);
      cfg(2'd0, 8'd3, 8'd2, 8'd1);
      run(400, 100, 0, 0);

      cur_req = "R8";
      cfg(2'd0, 8'd0, 8'd0, 8'd0);
      run(300, 100, 0, 60);

      cur_req = "R4";
      cfg(2'd1, 8'd2, 8'd4, 8'd6);
      run(1000, 75, 40, 5);

      cur_req = "R5";
      cfg(2'd2, 8'd0, 8'hFF, 8'd1);
      run(2200, 100, 30, 0);
      cfg(2'd2, 8'd0, 8'd3, 8'd1);
      run(1200, 100, 0, 0);

      cur_req = "R6";
      cfg(2'd3, 8'd7, 8'd3, 8'd1);
      run(2400, 100, 50, 0);

      cur_req = "R10";
      cfg(2'd3, 8'd0, 8'd0, 8'd0);
      run(400, 90, 50, 0);

      // R7: one-clock pulse between enabled cycles is dropped
      cur_req = "R7";
      cfg(2'd3, 8'd0, 8'hFF, 8'hFF);
      @(negedge clk); cyc_en = 1; evt_in = 0;
      @(negedge clk); cyc_en = 0;
      snap_lo = m_lo; snap_hi = m_hi;
      @(negedge clk); evt_in = 1;
      @(negedge clk); evt_in = 0;
      @(negedge clk); cyc_en = 1;
      @(negedge clk); cyc_en = 0;
      check("R7", "glitch not counted", {hi_count, lo_count}, {snap_hi, snap_lo});
      @(negedge clk); evt_in = 1; cyc_en = 1;
      @(negedge clk); cyc_en = 0;
      check("R7", "held level counted", {hi_count, lo_count}, {snap_hi, snap_lo} + 16'd1);
      evt_in = 0;

      // R11: enable low, nothing moves
      cur_req = "R11";
      cfg(2'd0, 8'd0, 8'hFF, 8'hFF);
      run(40, 100, 0, 0);
      snap_lo = lo_count; snap_hi = hi_count;
      run(80, 0, 50, 0);
      check("R11", "hold while disabled", {hi_count, lo_count}, {snap_hi, snap_lo});

      // R9: mode write mid-run zeroes counts, keeps flags
      cur_req = "R9";
      cfg(2'd1, 8'd0, 8'd2, 8'd2);
      run(300, 100, 50, 0);
      cfg(2'd0, 8'd0, 8'd2, 8'd2);
      run(30, 100, 0, 0);
      @(negedge clk);
      mode_wr = 1; mode_wdata = 2'd2;
      @(negedge clk);
      mode_wr = 0;
      check("R9", "counts after mode write", {hi_count, lo_count}, 16'h0);

      cur_req = "R3";
      for (int r = 0; r < 6; r++) begin
         cfg(2'($urandom % 4), 8'($urandom % 4), 8'($urandom % 8), 8'($urandom % 3));
         run(1500, 60 + ($urandom % 40), 40, 4);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule